// File: doc/BRIEF.md
# Interrupt Status and Enable Controller

This block gathers eight single-cycle event flags from an I2C master engine into sticky status bits. The host reads those bits through a small 32-bit register port and acknowledges them by writing ones. A per-bit enable mask selects which status bits may raise the interrupt, and a global enable bit at bit 31 can shut the output off as a whole. The single level-sensitive `irq_o` line is high whenever the global enable is set and at least one enabled status bit is pending.

A keyed reset register is also part of the block. Writing the exact key value 0xA there clears every register in the block. The block then drives a one-cycle `soft_rst_o` pulse, which the surrounding master uses to restart. Reads need no strobe. `rdata_o` follows `addr_i` combinationally from the register state.

Top module: `irq_event_ctrl`

## Requirements
- R1: Status bit i is set on the clock edge at which `evt_i[i]` is high. The bit order is fixed: 0 arbitration lost, 1 transmit error or transfer complete, 2 transmit FIFO empty, 3 receive FIFO at its level, 4 bus idle, 5 addressed as slave, 6 no longer addressed as slave, 7 transmit FIFO half empty. Status reads at offset 0x20 in bits 7:0, and bits 31:8 read zero.
- R2: A set status bit stays set after its event falls until the host clears it.
- R3: A write to offset 0x20 clears each status bit whose write-data bit is 1 and leaves each bit whose write-data bit is 0 unchanged.
- R4: If a status bit's event is high in the same cycle as a write that clears it, the bit stays set.
- R5: The enable mask is written and read at offset 0x28 in bits 7:0. Bits 31:8 read zero.
- R6: The global enable is bit 31 of offset 0x1C. The other bits of that register read zero and are ignored on write.
- R7: `irq_o` is 1 exactly when the global enable is 1 and (status AND enable) is non-zero. It follows the register contents with no extra cycle.
- R8: Writing 0xA to offset 0x40 clears status, enable and global enable on that clock edge. `soft_rst_o` is then high for exactly the one following cycle. A second key write made while the pulse is high is ignored.
- R9: Writing any value other than 0xA to offset 0x40 changes no register and raises no pulse.
- R10: Reads of offset 0x40 and of unmapped offsets return zero. Writes to unmapped offsets change nothing.
- R11: After `rst_ni` is released, all registers are zero, `irq_o` is 0 and `soft_rst_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| evt_i | input | 8 | Event flags from the master, one per status bit |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 8 | Register byte offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i` |
| irq_o | output | 1 | Interrupt request to the host |
| soft_rst_o | output | 1 | One-cycle reset pulse after a key write |

## Verification
The bench builds the block with its default eight event sources, which makes the whole mask space small enough to sweep. Every one of the 256 write-one-clear masks and every one of the 256 enable patterns is applied. The enable sweep is crossed with several status patterns and with both global-enable states, and each expected interrupt level is computed arithmetically. The keyed reset is driven with the key, with near-miss values and back to back, and an event is made to collide with its own clear.

// File: rtl/irq_event_ctrl_pkg.sv
package irq_event_ctrl_pkg;
  localparam int unsigned DATA_W = 32;

  typedef struct packed {
    logic gie_wr;
    logic sts_wr;
    logic ena_wr;
    logic key_hit;
  } reg_wr_t;
endpackage

// File: rtl/irq_reg_decode.sv
module irq_reg_decode
  import irq_event_ctrl_pkg::*;
#(
  parameter int unsigned NUM_EVT = 8,
  parameter int unsigned ADDR_W  = 8,
  parameter int unsigned GIE_OFF = 'h1C,
  parameter int unsigned STS_OFF = 'h20,
  parameter int unsigned ENA_OFF = 'h28,
  parameter int unsigned RST_OFF = 'h40,
  parameter int unsigned RST_KEY = 'hA
) (
  input  logic               wr_en_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  input  logic               gie_i,
  input  logic [NUM_EVT-1:0] sts_i,
  input  logic [NUM_EVT-1:0] ena_i,
  output reg_wr_t            wr_o,
  output logic [DATA_W-1:0]  rdata_o
);
  localparam int unsigned PAD_W = DATA_W - NUM_EVT;

  logic hit_gie, hit_sts, hit_ena, hit_rst;

  assign hit_gie = (addr_i == ADDR_W'(GIE_OFF));
  assign hit_sts = (addr_i == ADDR_W'(STS_OFF));
  assign hit_ena = (addr_i == ADDR_W'(ENA_OFF));
  assign hit_rst = (addr_i == ADDR_W'(RST_OFF));

  always_comb begin
    wr_o.gie_wr  = wr_en_i & hit_gie;
    wr_o.sts_wr  = wr_en_i & hit_sts;
    wr_o.ena_wr  = wr_en_i & hit_ena;
    wr_o.key_hit = wr_en_i & hit_rst & (wdata_i == DATA_W'(RST_KEY));
  end

  always_comb begin
    rdata_o = '0;
    if (hit_gie)      rdata_o = {gie_i, {(DATA_W-1){1'b0}}};
    else if (hit_sts) rdata_o = {{PAD_W{1'b0}}, sts_i};
    else if (hit_ena) rdata_o = {{PAD_W{1'b0}}, ena_i};
  end
endmodule

// File: rtl/irq_status_reg.sv
module irq_status_reg #(
  parameter int unsigned NUM_EVT = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clr_all_i,
  input  logic [NUM_EVT-1:0] evt_i,
  input  logic               clr_wr_i,
  input  logic [NUM_EVT-1:0] clr_mask_i,
  output logic [NUM_EVT-1:0] sts_o
);
  for (genvar i = 0; i < NUM_EVT; i++) begin : g_bit
    logic bit_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                        bit_q <= 1'b0;
      else if (clr_all_i)                 bit_q <= 1'b0;
      else if (evt_i[i])                  bit_q <= 1'b1;  // set beats clear
      else if (clr_wr_i && clr_mask_i[i]) bit_q <= 1'b0;
    end
    assign sts_o[i] = bit_q;
  end
endmodule

// File: rtl/irq_soft_reset.sv
module irq_soft_reset (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic key_hit_i,
  output logic fire_o,
  output logic pulse_o
);
  logic pulse_q;

  // key write while pulse is high is dropped, so pulse never stretches
  assign fire_o = key_hit_i & ~pulse_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pulse_q <= 1'b0;
    else         pulse_q <= fire_o;
  end

  assign pulse_o = pulse_q;
endmodule

// File: rtl/irq_gate.sv
module irq_gate #(
  parameter int unsigned NUM_EVT = 8
) (
  input  logic [NUM_EVT-1:0] sts_i,
  input  logic [NUM_EVT-1:0] ena_i,
  input  logic               gie_i,
  output logic               irq_o
);
  logic [NUM_EVT-1:0] pend;

  assign pend  = sts_i & ena_i;
  assign irq_o = gie_i & (|pend);
endmodule

// File: rtl/irq_event_ctrl.sv
module irq_event_ctrl
  import irq_event_ctrl_pkg::*;
#(
  parameter int unsigned NUM_EVT = 8,
  parameter int unsigned ADDR_W  = 8,
  parameter int unsigned GIE_OFF = 'h1C,
  parameter int unsigned STS_OFF = 'h20,
  parameter int unsigned ENA_OFF = 'h28,
  parameter int unsigned RST_OFF = 'h40,
  parameter int unsigned RST_KEY = 'hA
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_EVT-1:0] evt_i,
  input  logic               wr_en_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [31:0]        wdata_i,
  output logic [31:0]        rdata_o,
  output logic               irq_o,
  output logic               soft_rst_o
);
  localparam int unsigned GIE_BIT = DATA_W - 1;

  reg_wr_t            wr;
  logic [NUM_EVT-1:0] sts_q;
  logic [NUM_EVT-1:0] ena_q;
  logic               gie_q;
  logic               srst_fire;

  irq_reg_decode #(
    .NUM_EVT(NUM_EVT), .ADDR_W(ADDR_W), .GIE_OFF(GIE_OFF), .STS_OFF(STS_OFF),
    .ENA_OFF(ENA_OFF), .RST_OFF(RST_OFF), .RST_KEY(RST_KEY)
  ) u_decode (
    .wr_en_i (wr_en_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .gie_i   (gie_q),
    .sts_i   (sts_q),
    .ena_i   (ena_q),
    .wr_o    (wr),
    .rdata_o (rdata_o)
  );

  irq_soft_reset u_srst (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .key_hit_i (wr.key_hit),
    .fire_o    (srst_fire),
    .pulse_o   (soft_rst_o)
  );

  irq_status_reg #(.NUM_EVT(NUM_EVT)) u_status (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_all_i  (srst_fire),
    .evt_i      (evt_i),
    .clr_wr_i   (wr.sts_wr),
    .clr_mask_i (wdata_i[NUM_EVT-1:0]),
    .sts_o      (sts_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ena_q <= '0;
      gie_q <= 1'b0;
    end else if (srst_fire) begin
      ena_q <= '0;
      gie_q <= 1'b0;
    end else begin
      if (wr.ena_wr) ena_q <= wdata_i[NUM_EVT-1:0];
      if (wr.gie_wr) gie_q <= wdata_i[GIE_BIT];
    end
  end

  irq_gate #(.NUM_EVT(NUM_EVT)) u_gate (
    .sts_i (sts_q),
    .ena_i (ena_q),
    .gie_i (gie_q),
    .irq_o (irq_o)
  );
endmodule

// File: rtl/irq_event_ctrl_chk.sv
module irq_event_ctrl_chk #(
  parameter int unsigned NUM_EVT = 8,
  parameter int unsigned ADDR_W  = 8,
  parameter int unsigned STS_OFF = 'h20,
  parameter int unsigned RST_OFF = 'h40,
  parameter int unsigned RST_KEY = 'hA
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [NUM_EVT-1:0] evt_i,
  input logic               wr_en_i,
  input logic [ADDR_W-1:0]  addr_i,
  input logic [31:0]        wdata_i,
  input logic               irq_o,
  input logic               soft_rst_o,
  input logic [NUM_EVT-1:0] sts_q,
  input logic [NUM_EVT-1:0] ena_q,
  input logic               gie_q
);
  logic key_wr, sts_wr;
  assign key_wr = wr_en_i && (addr_i == ADDR_W'(RST_OFF)) && (wdata_i == 32'(RST_KEY));
  assign sts_wr = wr_en_i && (addr_i == ADDR_W'(STS_OFF));

  // R1 R4: an event always lands in status unless a reset fires
  p_evt_sets_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!key_wr) |=> ((sts_q & $past(evt_i)) == $past(evt_i)));

  // R3: ones clear bits without a colliding event
  p_w1c_clears_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sts_wr && !key_wr) |=> ((sts_q & $past(wdata_i[NUM_EVT-1:0] & ~evt_i)) == '0));

  // R2: no event, no clear, no reset -> status holds
  p_sticky_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sts_wr && !key_wr && evt_i == '0) |=> $stable(sts_q));

  // R7: output gated by global enable
  p_gie_gate_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gie_q |-> !irq_o);

  // R7: output silent with nothing pending
  p_no_pend_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((sts_q & ena_q) == '0) |-> !irq_o);

  // R8: key write yields a pulse with registers cleared
  p_key_reset_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (key_wr && !soft_rst_o) |=> (soft_rst_o && sts_q == '0 && ena_q == '0 && !gie_q));

  // R8: pulse is one cycle wide
  p_pulse_one_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_o |=> !soft_rst_o);

  // R9: pulse only follows a key write
  p_no_spurious_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!key_wr) |=> !soft_rst_o);
endmodule

bind irq_event_ctrl irq_event_ctrl_chk #(
  .NUM_EVT(NUM_EVT), .ADDR_W(ADDR_W), .STS_OFF(STS_OFF),
  .RST_OFF(RST_OFF), .RST_KEY(RST_KEY)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .evt_i      (evt_i),
  .wr_en_i    (wr_en_i),
  .addr_i     (addr_i),
  .wdata_i    (wdata_i),
  .irq_o      (irq_o),
  .soft_rst_o (soft_rst_o),
  .sts_q      (sts_q),
  .ena_q      (ena_q),
  .gie_q      (gie_q)
);

// File: tb/irq_event_ctrl_bench.sv
`timescale 1ns/1ps
module irq_event_ctrl_bench;
  localparam logic [7:0] A_GIE = 8'h1C, A_STS = 8'h20, A_ENA = 8'h28, A_RST = 8'h40, A_GAP = 8'h24;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  evt_i = '0;
  logic        wr_en_i = 1'b0;
  logic [7:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        irq_o, soft_rst_o;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  irq_event_ctrl u_irq_event_ctrl (
    .clk_i, .rst_ni, .evt_i, .wr_en_i, .addr_i, .wdata_i,
    .rdata_o, .irq_o, .soft_rst_o
  );

  always #4 clk_i = ~clk_i;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic wr_evt(logic [7:0] a, logic [31:0] d, logic [7:0] ev);
    @(negedge clk_i);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d; evt_i = ev;
    @(negedge clk_i);
    wr_en_i = 1'b0; evt_i = '0;
  endtask

  task automatic pulse_evt(logic [7:0] ev);
    @(negedge clk_i);
    evt_i = ev;
    @(negedge clk_i);
    evt_i = '0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] v);
    addr_i = a;
    #1;
    v = rdata_o;
  endtask

  initial begin
    #(8 * 190000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 32'd0, 32'd1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R11 reset state
    rd(A_GIE, v); chk("R11 gie", v, 0);
    rd(A_STS, v); chk("R11 sts", v, 0);
    rd(A_ENA, v); chk("R11 ena", v, 0);
    chk("R11 irq", {31'd0, irq_o}, 0);
    chk("R11 pulse", {31'd0, soft_rst_o}, 0);

    // R1 per-bit event mapping
    for (int i = 0; i < 8; i++) begin
      pulse_evt(8'(1 << i));
      rd(A_STS, v); chk("R1 bit", v, 32'(1 << i));
      wr(A_STS, 32'hFFFF_FFFF);
      rd(A_STS, v); chk("R3 clear all", v, 0);
    end

    // R2 sticky
    pulse_evt(8'h24);
    repeat (6) @(negedge clk_i);
    rd(A_STS, v); chk("R2 sticky", v, 32'h24);

    // R3 all clear masks
    for (int m = 0; m < 256; m++) begin
      pulse_evt(8'hFF);
      wr(A_STS, 32'(m));
      rd(A_STS, v); chk("R3 w1c", v, 32'(8'hFF & ~8'(m)));
    end
    wr(A_STS, 32'hFF);

    // R4 event collides with its clear
    pulse_evt(8'h81);
    wr_evt(A_STS, 32'h81, 8'h01);
    rd(A_STS, v); chk("R4 collide", v, 32'h01);
    wr(A_STS, 32'hFF);

    // R5 enable readback
    for (int e = 0; e < 256; e++) begin
      wr(A_ENA, 32'hFFFF_FF00 | 32'(e));
      rd(A_ENA, v); chk("R5 ena", v, 32'(e));
    end

    // R6 global enable bit
    wr(A_GIE, 32'h7FFF_FFFF);
    rd(A_GIE, v); chk("R6 gie low bits", v, 0);
    wr(A_GIE, 32'h8000_0000);
    rd(A_GIE, v); chk("R6 gie set", v, 32'h8000_0000);

    // R7 interrupt gating sweep
    begin
      logic [7:0] pats [5] = '{8'h00, 8'h01, 8'h80, 8'h5A, 8'hFF};
      foreach (pats[k]) begin
        wr(A_STS, 32'hFF);
        pulse_evt(pats[k]);
        for (int g = 0; g < 2; g++) begin
          wr(A_GIE, 32'(g) << 31);
          for (int e = 0; e < 256; e++) begin
            wr(A_ENA, 32'(e));
            #1;
            chk("R7 irq", {31'd0, irq_o},
                {31'd0, (g == 1) && ((pats[k] & 8'(e)) != 0)});
          end
        end
      end
    end

    // R9 near-miss keys
    wr(A_STS, 32'hFF);
    pulse_evt(8'h3C);
    wr(A_ENA, 32'h0F);
    wr(A_GIE, 32'h8000_0000);
    begin
      logic [31:0] bad [4] = '{32'h0, 32'hB, 32'h1A, 32'h8000_000A};
      foreach (bad[k]) begin
        wr(A_RST, bad[k]);
        chk("R9 no pulse", {31'd0, soft_rst_o}, 0);
        rd(A_STS, v); chk("R9 sts kept", v, 32'h3C);
        rd(A_ENA, v); chk("R9 ena kept", v, 32'h0F);
        rd(A_GIE, v); chk("R9 gie kept", v, 32'h8000_0000);
      end
    end

    // R10 unmapped and reset-register reads, unmapped write
    rd(A_RST, v); chk("R10 rst reads 0", v, 0);
    rd(A_GAP, v); chk("R10 gap reads 0", v, 0);
    wr(A_GAP, 32'hFFFF_FFFF);
    rd(A_STS, v); chk("R10 sts kept", v, 32'h3C);
    rd(A_ENA, v); chk("R10 ena kept", v, 32'h0F);
    chk("R10 irq kept", {31'd0, irq_o}, 1);

    // R8 keyed reset
    wr(A_RST, 32'hA);
    chk("R8 pulse high", {31'd0, soft_rst_o}, 1);
    rd(A_STS, v); chk("R8 sts cleared", v, 0);
    rd(A_ENA, v); chk("R8 ena cleared", v, 0);
    rd(A_GIE, v); chk("R8 gie cleared", v, 0);
    chk("R8 irq low", {31'd0, irq_o}, 0);
    @(negedge clk_i);
    chk("R8 pulse one cycle", {31'd0, soft_rst_o}, 0);

    // R8 back-to-back key writes: second dropped
    wr(A_ENA, 32'h11);
    @(negedge clk_i);
    wr_en_i = 1'b1; addr_i = A_RST; wdata_i = 32'hA;
    @(negedge clk_i);
    chk("R8 b2b first pulse", {31'd0, soft_rst_o}, 1);
    @(negedge clk_i);
    wr_en_i = 1'b0;
    chk("R8 b2b no second", {31'd0, soft_rst_o}, 0);
    @(negedge clk_i);
    chk("R8 b2b stays low", {31'd0, soft_rst_o}, 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule